// File: doc/BRIEF.md
# Chained Front-End Packet Merger with Back-Pressure

Each front-end chip in a readout chain carries one of these blocks. It gathers fixed-length packets from three queues and sends them one bit at a time toward the next chip. The first queue holds hit packets from the local zero-suppression logic. The second holds register-readback packets. The third holds packets that arrive serially from the previous chip in the chain. The block never looks inside a packet. It counts the bits it sends, hands the output to one queue for a whole packet, and lets packets from different events interleave as they come.

Flow control runs in both directions. The downstream chip grants permission through a level input. The block reads that input only between packets, so a packet that has started always finishes. In the other direction the block drives its own permission level toward the previous chip. It drops that level as soon as the forwarding queue, counting a packet still being assembled, has no room left for another whole packet. Any packet that the block has accepted is therefore never lost.

Top module: `chain_readout_arbiter`

## Requirements
- R1: After reset, `ser_valid_o` is 0, `xon_up_o` is 1, and `evt_full_o` and `reg_full_o` are 0.
- R2: Every packet goes out as exactly PKT_BITS (default 55) consecutive cycles with `ser_valid_o` high. Bits leave most significant first, and the bit pattern is unchanged.
- R3: Sources are served round-robin among those with a waiting packet, in the cyclic order event (0), register (1), forwarded (2). The first grant after reset starts the search at the event source.
- R4: `xon_dn_i` is sampled only at packet boundaries. A packet that has started completes even if `xon_dn_i` falls during it, and no new packet starts while `xon_dn_i` is low.
- R5: `xon_up_o` is 0 whenever the stored forwarded packets plus a partly received one fill all UP_DEPTH (default 4) slots. Otherwise it is 1.
- R6: Bits on `up_bit_i` are taken only in cycles where `up_stb_i` is high, most significant first. Every PKT_BITS strobed bits form one packet, which is later sent unchanged.
- R7: A write to a full local queue is ignored, and the matching full flag is high while that queue holds its depth in packets (EVT_DEPTH default 4). Accepted packets are never dropped and leave in the order they were written, per source.
- R8: When the next packet is ready and `xon_dn_i` is high at a boundary, the next packet starts in the cycle right after the last bit of the current one, with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_wr_i | input | 1 | Write strobe for a local hit packet |
| evt_pkt_i | input | PKT_BITS | Local hit packet |
| evt_full_o | output | 1 | Local hit queue full |
| reg_wr_i | input | 1 | Write strobe for a readback packet |
| reg_pkt_i | input | PKT_BITS | Readback packet |
| reg_full_o | output | 1 | Readback queue full |
| up_bit_i | input | 1 | Serial data from the previous chip |
| up_stb_i | input | 1 | Bit strobe from the previous chip |
| xon_up_o | output | 1 | Permission level to the previous chip |
| xon_dn_i | input | 1 | Permission level from the next chip |
| ser_bit_o | output | 1 | Serial data to the next chip |
| ser_valid_o | output | 1 | Bit strobe to the next chip |

## Verification
A wrong bit counter shows at the ports within a single packet. The output strobe either breaks before PKT_BITS cycles or runs past them, so the received word shifts and fails its comparison. A wrong arbitration pointer shows at the second packet of a mixed burst as an out-of-order source tag. A wrong occupancy count for the forwarding queue shows as `xon_up_o` staying high with every slot taken, or dropping early with one slot still free. Either fault is visible in the cycle after the packet that crosses the limit completes.

// File: rtl/chain_rd_pkg.sv
package chain_rd_pkg;
   localparam int SRC_N = 3;
   typedef enum logic [1:0] {
      SRC_EVT = 2'd0,
      SRC_REG = 2'd1,
      SRC_UP  = 2'd2
   } src_e;
endpackage

// File: rtl/pkt_fifo.sv
module pkt_fifo #(
   parameter int W     = 55,
   parameter int DEPTH = 4,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic          empty,
   output logic          full,
   output logic [LW-1:0] level
);
   if (DEPTH < 1) begin : g_bad_depth
      $error("pkt_fifo: DEPTH must be at least 1");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic          do_push, do_pop;

   assign empty   = (level == '0);
   assign full    = (level == LW'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
         level <= level + LW'(do_push) - LW'(do_pop);
      end
   end
endmodule

// File: rtl/serial_packer.sv
module serial_packer #(
   parameter int W   = 55,
   localparam int CW = $clog2(W)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         bit_i,
   input  logic         stb_i,
   output logic [W-1:0] pkt_o,
   output logic         done_o,
   output logic         busy_o
);
   if (W < 2) begin : g_bad_width
      $error("serial_packer: W must be at least 2");
   end

   logic [W-2:0]  sh;
   logic [CW-1:0] cnt;

   assign done_o = stb_i && (cnt == CW'(W - 1));
   assign pkt_o  = {sh, bit_i};
   assign busy_o = (cnt != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh  <= '0;
         cnt <= '0;
      end else if (stb_i) begin
         sh  <= {sh[W-3:0], bit_i};
         cnt <= done_o ? '0 : cnt + 1'b1;
      end
   end
endmodule

// File: rtl/rr_arbiter.sv
module rr_arbiter #(
   parameter int N   = 3,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   input  logic          advance,
   output logic [N-1:0]  grant,
   output logic [IW-1:0] idx,
   output logic          any
);
   logic [IW-1:0] last;

   always_comb begin
      grant = '0;
      idx   = '0;
      any   = 1'b0;
      for (int k = 1; k <= N; k++) begin
         int cand;
         cand = (int'(last) + k) % N;
         if (!any && req[cand]) begin
            any         = 1'b1;
            idx         = IW'(cand);
            grant[cand] = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                last <= IW'(N - 1);
      else if (advance && any)   last <= idx;
   end
endmodule

// File: rtl/chain_readout_arbiter.sv
module chain_readout_arbiter
   import chain_rd_pkg::*;
#(
   parameter int PKT_BITS  = 55,
   parameter int EVT_DEPTH = 4,
   parameter int REG_DEPTH = 2,
   parameter int UP_DEPTH  = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                evt_wr_i,
   input  logic [PKT_BITS-1:0] evt_pkt_i,
   output logic                evt_full_o,
   input  logic                reg_wr_i,
   input  logic [PKT_BITS-1:0] reg_pkt_i,
   output logic                reg_full_o,
   input  logic                up_bit_i,
   input  logic                up_stb_i,
   output logic                xon_up_o,
   input  logic                xon_dn_i,
   output logic                ser_bit_o,
   output logic                ser_valid_o
);
   localparam int CW    = $clog2(PKT_BITS);
   localparam int UP_LW = $clog2(UP_DEPTH + 1);
   localparam int IW    = $clog2(SRC_N);

   if (PKT_BITS < 2) begin : g_bad_pkt
      $error("chain_readout_arbiter: PKT_BITS must be at least 2");
   end

   logic [PKT_BITS-1:0] head [SRC_N];
   logic [SRC_N-1:0]    nonempty, grant, pops;
   logic [IW-1:0]       pick;
   logic                any_req;
   logic                evt_empty, reg_empty, up_empty;
   logic                up_full, up_push, up_busy;
   logic [PKT_BITS-1:0] up_pkt;
   logic [UP_LW-1:0]    up_level;
   logic [$clog2(EVT_DEPTH+1)-1:0] evt_level;
   logic [$clog2(REG_DEPTH+1)-1:0] reg_level;

   logic [PKT_BITS-1:0] shreg;
   logic [CW-1:0]       bit_cnt;
   logic                busy, boundary, start;

   pkt_fifo #(.W(PKT_BITS), .DEPTH(EVT_DEPTH)) u_evt_fifo (
      .clk(clk), .rst_n(rst_n), .push(evt_wr_i), .din(evt_pkt_i),
      .pop(pops[SRC_EVT]), .dout(head[SRC_EVT]), .empty(evt_empty),
      .full(evt_full_o), .level(evt_level));

   pkt_fifo #(.W(PKT_BITS), .DEPTH(REG_DEPTH)) u_reg_fifo (
      .clk(clk), .rst_n(rst_n), .push(reg_wr_i), .din(reg_pkt_i),
      .pop(pops[SRC_REG]), .dout(head[SRC_REG]), .empty(reg_empty),
      .full(reg_full_o), .level(reg_level));

   serial_packer #(.W(PKT_BITS)) u_up_packer (
      .clk(clk), .rst_n(rst_n), .bit_i(up_bit_i), .stb_i(up_stb_i),
      .pkt_o(up_pkt), .done_o(up_push), .busy_o(up_busy));

   pkt_fifo #(.W(PKT_BITS), .DEPTH(UP_DEPTH)) u_up_fifo (
      .clk(clk), .rst_n(rst_n), .push(up_push), .din(up_pkt),
      .pop(pops[SRC_UP]), .dout(head[SRC_UP]), .empty(up_empty),
      .full(up_full), .level(up_level));

   // room is reserved for a packet as soon as its first bit arrives
   assign xon_up_o = (32'(up_level) + 32'(up_busy)) < UP_DEPTH;

   assign nonempty = {!up_empty, !reg_empty, !evt_empty};

   rr_arbiter #(.N(SRC_N)) u_rr (
      .clk(clk), .rst_n(rst_n), .req(nonempty), .advance(start),
      .grant(grant), .idx(pick), .any(any_req));

   assign boundary = !busy || (bit_cnt == CW'(PKT_BITS - 1));
   assign start    = boundary && xon_dn_i && any_req;
   assign pops     = grant & {SRC_N{start}};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg   <= '0;
         bit_cnt <= '0;
         busy    <= 1'b0;
      end else if (start) begin
         shreg   <= head[pick];
         bit_cnt <= '0;
         busy    <= 1'b1;
      end else if (busy) begin
         shreg   <= {shreg[PKT_BITS-2:0], 1'b0};
         bit_cnt <= bit_cnt + 1'b1;
         if (bit_cnt == CW'(PKT_BITS - 1)) busy <= 1'b0;
      end
   end

   assign ser_bit_o   = shreg[PKT_BITS-1];
   assign ser_valid_o = busy;
endmodule

// File: rtl/chain_readout_arbiter_chk.sv
module chain_readout_arbiter_chk #(
   parameter int PKT_BITS = 55,
   parameter int UP_DEPTH = 4,
   localparam int UP_LW   = $clog2(UP_DEPTH + 1),
   localparam int CW      = $clog2(PKT_BITS)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ser_valid_o,
   input logic             xon_dn_i,
   input logic             xon_up_o,
   input logic [UP_LW-1:0] up_level,
   input logic             up_push,
   input logic [2:0]       grant
);
   logic [CW-1:0] seen;

   always_ff @(posedge clk) begin
      if (!rst_n) seen <= '0;
      else if (ser_valid_o)
         seen <= (seen == CW'(PKT_BITS - 1)) ? '0 : seen + 1'b1;
   end

   assert_pkt_unbroken_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (seen != '0) |-> ser_valid_o);

   assert_xon_at_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_valid_o && seen == '0) |-> $past(xon_dn_i));

   assert_up_full_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (up_level == UP_LW'(UP_DEPTH)) |-> !xon_up_o);

   assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(up_push && up_level == UP_LW'(UP_DEPTH)));

   assert_grant_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
endmodule

bind chain_readout_arbiter chain_readout_arbiter_chk #(
   .PKT_BITS(PKT_BITS), .UP_DEPTH(UP_DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .ser_valid_o(ser_valid_o), .xon_dn_i(xon_dn_i),
   .xon_up_o(xon_up_o), .up_level(up_level), .up_push(up_push), .grant(grant));

// File: tb/chain_readout_arbiter_bench.sv
module chain_readout_arbiter_bench;
   localparam int W = 55;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         evt_wr_i = 1'b0, reg_wr_i = 1'b0;
   logic [W-1:0] evt_pkt_i = '0, reg_pkt_i = '0;
   logic         evt_full_o, reg_full_o;
   logic         up_bit_i = 1'b0, up_stb_i = 1'b0;
   logic         xon_up_o, xon_dn_i = 1'b0;
   logic         ser_bit_o, ser_valid_o;

   int checks = 0, fails = 0, rx_pkts = 0, rx_cnt = 0;
   bit finished = 0;
   logic [W-1:0] rx_word = '0;
   logic [W-1:0] exp_q [$];

   always #2 clk = ~clk;

   chain_readout_arbiter u_chain_readout_arbiter (.*);

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [W-1:0] mk(input int src, input int n);
      return {2'(src), 53'(64'h1_5A3C_96E1_7B2D * (n + 7)) ^ 53'(n)};
   endfunction

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && ser_valid_o) begin
         rx_word = {rx_word[W-2:0], ser_bit_o};
         rx_cnt++;
         if (rx_cnt == W) begin
            rx_cnt = 0;
            rx_pkts++;
            if (exp_q.size() == 0) chk(0, "R2 unexpected packet", longint'(rx_word), 0);
            else begin
               logic [W-1:0] e;
               e = exp_q.pop_front();
               chk(rx_word == e, "R2/R3/R7 packet content", longint'(rx_word), longint'(e));
            end
         end
      end
   end

   task automatic push_evt(input logic [W-1:0] p);
      evt_pkt_i = p; evt_wr_i = 1'b1; @(negedge clk); evt_wr_i = 1'b0;
   endtask
   task automatic push_reg(input logic [W-1:0] p);
      reg_pkt_i = p; reg_wr_i = 1'b1; @(negedge clk); reg_wr_i = 1'b0;
   endtask
   task automatic send_up(input logic [W-1:0] p);
      while (!xon_up_o) @(negedge clk);
      for (int i = W - 1; i >= 0; i--) begin
         up_bit_i = p[i]; up_stb_i = 1'b1; @(negedge clk);
      end
      up_stb_i = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!ser_valid_o, "R1 ser_valid", ser_valid_o, 0);
      chk(xon_up_o, "R1 xon_up", xon_up_o, 1);
      chk(!evt_full_o && !reg_full_o, "R1 full flags", {evt_full_o, reg_full_o}, 0);

      // R3 R6 R8 round robin with all sources loaded, stalled by xon_dn low
      push_evt(mk(0, 1)); push_evt(mk(0, 2));
      push_reg(mk(1, 3)); push_reg(mk(1, 4));
      send_up(mk(2, 5)); send_up(mk(2, 6));
      chk(!ser_valid_o, "R4 no start while xon_dn low", ser_valid_o, 0);
      exp_q.push_back(mk(0, 1)); exp_q.push_back(mk(1, 3)); exp_q.push_back(mk(2, 5));
      exp_q.push_back(mk(0, 2)); exp_q.push_back(mk(1, 4)); exp_q.push_back(mk(2, 6));
      xon_dn_i = 1'b1;
      @(negedge clk);
      begin
         int gaps = 0;
         for (int c = 0; c < 6 * W; c++) begin
            if (!ser_valid_o) gaps++;
            @(negedge clk);
         end
         chk(gaps == 0, "R8 back-to-back burst gaps", gaps, 0);
      end
      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0 && rx_pkts == 6, "R3 burst drained", rx_pkts, 6);

      // R4 xon_dn falls mid-packet
      push_evt(mk(0, 10)); push_evt(mk(0, 11));
      exp_q.push_back(mk(0, 10)); exp_q.push_back(mk(0, 11));
      repeat (10) @(negedge clk);
      xon_dn_i = 1'b0;
      repeat (W + 20) @(negedge clk);
      chk(rx_pkts == 7, "R4 started packet completes", rx_pkts, 7);
      chk(!ser_valid_o, "R4 held after boundary", ser_valid_o, 0);
      xon_dn_i = 1'b1;
      repeat (W + 5) @(negedge clk);
      chk(rx_pkts == 8, "R4 resumes on xon", rx_pkts, 8);

      // R7 write to full event queue ignored
      xon_dn_i = 1'b0;
      for (int i = 0; i < 4; i++) begin
         push_evt(mk(0, 20 + i));
         exp_q.push_back(mk(0, 20 + i));
      end
      chk(evt_full_o, "R7 full flag at depth", evt_full_o, 1);
      push_evt(mk(0, 99));
      xon_dn_i = 1'b1;
      repeat (4 * W + 10) @(negedge clk);
      chk(rx_pkts == 12 && exp_q.size() == 0, "R7 dropped write not sent", rx_pkts, 12);
      chk(!evt_full_o, "R7 full clears", evt_full_o, 0);

      // R5 upstream permission level
      xon_dn_i = 1'b0;
      for (int i = 0; i < 3; i++) begin
         send_up(mk(2, 30 + i));
         exp_q.push_back(mk(2, 30 + i));
      end
      chk(xon_up_o, "R5 xon_up with one slot free", xon_up_o, 1);
      for (int i = W - 1; i >= 0; i--) begin
         up_bit_i = mk(2, 33)[i]; up_stb_i = 1'b1; @(negedge clk);
         if (i == 40) chk(!xon_up_o, "R5 partial packet reserves slot", xon_up_o, 0);
      end
      up_stb_i = 1'b0;
      exp_q.push_back(mk(2, 33));
      chk(!xon_up_o, "R5 xon_up low when full", xon_up_o, 0);
      xon_dn_i = 1'b1;
      repeat (W + 5) @(negedge clk);
      chk(xon_up_o, "R5 xon_up returns", xon_up_o, 1);
      repeat (3 * W + 10) @(negedge clk);
      chk(rx_pkts == 16 && exp_q.size() == 0, "R6 forwarded packets intact", rx_pkts, 16);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule